// File: doc/BRIEF.md
# Vehicle Alarm and Courtesy-Light Controller

This controller runs on one free-running clock and looks after two jobs in a car. The first is the interior dome lamp. The lamp lights when it is dark and either any door is open or the dashboard cabin switch is on.

The second job is a simple intrusion alarm. A keyfob receiver sends pulses, and each new pulse flips the system between armed and disarmed. While the system is armed, opening any door raises the alarm. The alarm then stays raised, even after every door closes, until the system is disarmed. Disarming forces the alarm low at once.

Every external input first passes through a multi-flop synchronizer. The keyfob input is also edge-detected on the system clock, so a long press counts as one pulse. A door that opens and closes within one clock period can go unseen. At a clock of several MHz this is accepted.

Top module: `car_guard_ctrl`

## Requirements
- R1: `dome_lamp_o` is 1 exactly when `dark_i` is 1 and at least one bit of `door_open_i` or `cabin_sw_i` is 1. It has no effect on the alarm.
- R2: Each 0-to-1 transition of `fob_i` flips the armed state exactly once, however many cycles `fob_i` stays high. Two transitions arm and then disarm.
- R3: While armed, any single bit of `door_open_i` at 1 sets `alarm_o` to 1.
- R4: Once set, `alarm_o` stays 1 while the system remains armed, even after all bits of `door_open_i` return to 0.
- R5: While disarmed, `alarm_o` is 0 whatever `door_open_i` does. Disarming clears a raised alarm.
- R6: Holding `rst` high at a rising edge of `clk` clears both the armed state and `alarm_o`. After reset the system is disarmed.
- R7: Every input passes through the synchronizer before it is used. A change on an input reaches `alarm_o` or `dome_lamp_o` on the third rising edge of `clk` after the change, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| door_open_i | input | NUM_DOORS | One bit per door, 1 = open (asynchronous) |
| cabin_sw_i | input | 1 | Dashboard interior-light switch (asynchronous) |
| dark_i | input | 1 | Darkness sensor, 1 = dark (asynchronous) |
| fob_i | input | 1 | Keyfob receiver pulse (asynchronous) |
| dome_lamp_o | output | 1 | Registered dome-lamp drive |
| alarm_o | output | 1 | Registered latched alarm |

## Verification
The bench holds the keyfob high for an odd number of cycles and later for an even number.
- A level-sensitive design would toggle on every cycle. Its armed state would then depend on the hold length, so a door opening would raise the alarm in the wrong case.

It closes every door after an alarm and watches the alarm for many cycles.
- A design whose alarm simply follows the doors would drop the alarm.

It disarms while a door is still open, and it resets in the middle of an alarm.
- A design whose clear does not take priority over the door trigger would keep or re-raise the alarm.

Finally, it samples the alarm one cycle before and exactly on the expected edge.
- This catches a synchronizer with a stage missing or a stage too many.

// File: rtl/cg_pkg.sv
package cg_pkg;
  parameter int unsigned CG_DEF_DOORS  = 4;
  parameter int unsigned CG_DEF_STAGES = 2;
endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = cg_pkg::CG_DEF_STAGES
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) stg_q[gi] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk) stg_q[gi] <= stg_q[gi-1];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cg_rise_detect.sv
module cg_rise_detect (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk) prev_q <= sig_i;

  assign rise_o = sig_i & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o); // R2
endmodule

// File: rtl/cg_arm_latch.sv
module cg_arm_latch (
  input  logic clk,
  input  logic rst,
  input  logic fob_rise_i,
  input  logic door_any_i,
  output logic alarm_o
);
  logic armed_q, armed_d;
  logic alarm_q, alarm_d;

  always_comb begin
    armed_d = fob_rise_i ? ~armed_q : armed_q;
    alarm_d = armed_d & (alarm_q | door_any_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      alarm_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
      alarm_q <= alarm_d;
    end
  end

  assign alarm_o = alarm_q;

  AST_ALARM_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
    alarm_q |-> armed_q); // R5
  AST_ARM_FLIPS: assert property (@(posedge clk) disable iff (rst)
    fob_rise_i |=> (armed_q != $past(armed_q))); // R2
  AST_ARM_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !fob_rise_i |=> $stable(armed_q)); // R2
  AST_DOOR_TRIGGERS: assert property (@(posedge clk) disable iff (rst)
    door_any_i |=> (armed_q -> alarm_q)); // R3
  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (rst)
    (alarm_q && !fob_rise_i) |=> alarm_q); // R4
endmodule

// File: rtl/cg_lamp.sv
module cg_lamp #(
  parameter int unsigned NUM_DOORS = cg_pkg::CG_DEF_DOORS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_DOORS-1:0] doors_i,
  input  logic                 sw_i,
  input  logic                 dark_i,
  output logic                 lamp_o
);
  logic lamp_q;

  always_ff @(posedge clk) lamp_q <= dark_i & ((|doors_i) | sw_i);

  assign lamp_o = lamp_q;

  AST_LAMP_NEEDS_DARK: assert property (@(posedge clk) disable iff (rst)
    !dark_i |=> !lamp_q); // R1
  AST_LAMP_SWITCH_ON: assert property (@(posedge clk) disable iff (rst)
    (dark_i && sw_i) |=> lamp_q); // R1
endmodule

// File: rtl/car_guard_ctrl.sv
module car_guard_ctrl #(
  parameter int unsigned NUM_DOORS   = cg_pkg::CG_DEF_DOORS,
  parameter int unsigned SYNC_STAGES = cg_pkg::CG_DEF_STAGES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_DOORS-1:0] door_open_i,
  input  logic                 cabin_sw_i,
  input  logic                 dark_i,
  input  logic                 fob_i,
  output logic                 dome_lamp_o,
  output logic                 alarm_o
);
  localparam int unsigned IN_W    = NUM_DOORS + 3;
  localparam int unsigned SW_BIT  = NUM_DOORS;
  localparam int unsigned DRK_BIT = NUM_DOORS + 1;
  localparam int unsigned FOB_BIT = NUM_DOORS + 2;

  logic [IN_W-1:0] raw_in, syn_in;
  logic            fob_rise;

  assign raw_in = {fob_i, dark_i, cabin_sw_i, door_open_i};

  cg_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d_i (raw_in),
    .q_o (syn_in)
  );

  cg_rise_detect u_fob_edge (
    .clk    (clk),
    .rst    (rst),
    .sig_i  (syn_in[FOB_BIT]),
    .rise_o (fob_rise)
  );

  cg_arm_latch u_guard (
    .clk        (clk),
    .rst        (rst),
    .fob_rise_i (fob_rise),
    .door_any_i (|syn_in[NUM_DOORS-1:0]),
    .alarm_o    (alarm_o)
  );

  cg_lamp #(.NUM_DOORS(NUM_DOORS)) u_lamp (
    .clk     (clk),
    .rst     (rst),
    .doors_i (syn_in[NUM_DOORS-1:0]),
    .sw_i    (syn_in[SW_BIT]),
    .dark_i  (syn_in[DRK_BIT]),
    .lamp_o  (dome_lamp_o)
  );
endmodule

// File: tb/test_car_guard_ctrl.sv
`timescale 1ns/1ps
module test_car_guard_ctrl;
  localparam int NDOOR = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NDOOR-1:0] doors = '0;
  logic             sw = 1'b0, dark = 1'b0, fob = 1'b0;
  logic             lamp, alarm;
  int               checks = 0, failures = 0;
  bit               done = 1'b0;

  always #2 clk = ~clk;

  car_guard_ctrl #(.NUM_DOORS(NDOOR)) i_car_guard_ctrl (
    .clk(clk), .rst(rst), .door_open_i(doors), .cabin_sw_i(sw),
    .dark_i(dark), .fob_i(fob), .dome_lamp_o(lamp), .alarm_o(alarm)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic press(input int n);
    fob = 1'b1; cyc(n); fob = 1'b0; cyc(4);
  endtask

  task automatic t_reset;
    rst = 1'b1; cyc(5);
    chk("R6 reset alarm", alarm, 1'b0);
    chk("R6 reset lamp", lamp, 1'b0);
    rst = 1'b0; cyc(2);
  endtask

  task automatic t_lamp_table;
    logic [NDOOR-1:0] pats [6] = '{4'h0, 4'h1, 4'h2, 4'h4, 4'h8, 4'h5};
    for (int d = 0; d < 2; d++)
      for (int s = 0; s < 2; s++)
        for (int p = 0; p < 6; p++) begin
          dark = d[0]; sw = s[0]; doors = pats[p];
          cyc(4);
          chk("R1 lamp", lamp, d[0] & (s[0] | (|pats[p])));
          chk("R5 lamp sweep no alarm", alarm, 1'b0);
        end
    dark = 1'b0; sw = 1'b0; doors = '0; cyc(4);
  endtask

  task automatic t_arm_latency;
    press(1);
    chk("R2 armed no door quiet", alarm, 1'b0);
    doors = 4'h4;
    cyc(2); chk("R7 alarm not before third edge", alarm, 1'b0);
    cyc(1); chk("R3 alarm on third edge", alarm, 1'b1);
  endtask

  task automatic t_sticky;
    doors = '0;
    for (int i = 0; i < 20; i++) begin
      cyc(1);
      if (i % 5 == 4) chk("R4 alarm sticky after close", alarm, 1'b1);
    end
  endtask

  task automatic t_disarm;
    doors = 4'h1;
    press(1);
    chk("R5 disarm clears with door open", alarm, 1'b0);
    cyc(10);
    chk("R5 stays clear while disarmed", alarm, 1'b0);
    doors = 4'hF; cyc(5);
    chk("R5 all doors disarmed", alarm, 1'b0);
    doors = '0; cyc(4);
  endtask

  task automatic t_long_press;
    press(9);
    chk("R2 long press no door", alarm, 1'b0);
    doors = 4'h8; cyc(4);
    chk("R2 odd-long press arms once", alarm, 1'b1);
    doors = '0;
    press(12);
    chk("R2 long press disarms", alarm, 1'b0);
    doors = 4'h2; cyc(5);
    chk("R2 even-long press leaves disarmed", alarm, 1'b0);
    doors = '0; cyc(4);
  endtask

  task automatic t_reset_mid;
    press(1);
    doors = 4'h1; cyc(4);
    chk("R3 rearm then door", alarm, 1'b1);
    doors = '0; cyc(4);
    rst = 1'b1; cyc(2);
    chk("R6 reset clears alarm", alarm, 1'b0);
    rst = 1'b0; cyc(1);
    doors = 4'h2; cyc(5);
    chk("R6 disarmed after reset", alarm, 1'b0);
    doors = '0; cyc(4);
  endtask

  initial begin
    t_reset;
    t_lamp_table;
    t_arm_latency;
    t_sticky;
    t_disarm;
    t_long_press;
    t_reset_mid;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule